// File: doc/BRIEF.md
# Timer Compare Unit with Event Trigger

This block holds a compare word and tests it on every clock cycle against an external free-running timer value. Each time the timer newly reaches the compare word, the unit takes the action picked by a 4-bit mode field. It can set an output latch high, drive it low, or leave it untouched and only raise an interrupt. In the trigger mode it emits a one-cycle event that the timer logic uses to restart from zero. That mode makes the compare word a programmable period. The same event can also start an ADC conversion.

Software loads the compare word and the mode through two write strobes. It reads and clears the interrupt flag through a clear strobe. The output latch reaches the pin only while the pin's direction input selects output. The trigger is a separate signal from any timer-overflow indication, so a period restart never looks like an overflow. The timer, its prescaler and the ADC sit outside this block.

Top module: `tcmp_unit`

## Requirements
- R1: After reset the output latch, the interrupt flag, `timer_clear` and `adc_go` are all 0. The stored compare word is 0 and the stored mode is 4'b0000.
- R2: A match event occurs in a cycle where `tmr_value` equals the stored compare word, the previous cycle had no equality, and the stored mode is one of 4'b1000 to 4'b1011. While the equality persists, no further event occurs. The action of an event is visible on the outputs one clock edge later.
- R3: Mode 4'b1000 sets the output latch to 1 on a match event.
- R4: Mode 4'b1001 clears the output latch to 0 on a match event.
- R5: Mode 4'b1010 leaves the output latch unchanged on a match event and only sets the interrupt flag.
- R6: Every match event sets the interrupt flag. The flag then stays 1 until a cycle with `irq_clr` high clears it. If a match event and a clear fall in the same cycle, the flag ends up set.
- R7: Mode 4'b1011 raises `timer_clear` for exactly one cycle on a match event and leaves the output latch unchanged. It never produces any timer-overflow indication.
- R8: `adc_go` pulses together with `timer_clear` only when `adc_enable` was high in the match cycle, and only when parameter HAS_ADC_LINK is 1.
- R9: A mode write of 4'b0000 forces the output latch to 0 at the next edge. This write wins over a match event in the same cycle.
- R10: `pin_drive_en` follows `pin_dir_out`. `pin_level` equals the output latch when `pin_dir_out` is 1, and is 0 otherwise.
- R11: Mode values outside 4'b1000 to 4'b1011 cause no event. The latch, the flag and the trigger do not change.
- R12: A compare-word write takes effect for matching from the cycle after the write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmp_we | input | 1 | Compare word write strobe |
| cmp_wdata | input | 16 | Compare word write data |
| mode_we | input | 1 | Mode field write strobe |
| mode_wdata | input | 4 | Mode field write data |
| tmr_value | input | 16 | Current timer value |
| adc_enable | input | 1 | ADC is enabled to accept a start |
| irq_clr | input | 1 | Software clear of the interrupt flag |
| irq_flag | output | 1 | Compare interrupt flag |
| cmp_out | output | 1 | Compare output latch |
| pin_dir_out | input | 1 | Pin direction, 1 selects output |
| pin_drive_en | output | 1 | Pin output enable |
| pin_level | output | 1 | Level driven on the pin |
| timer_clear | output | 1 | Special event trigger, restarts the timer |
| adc_go | output | 1 | ADC conversion start pulse |

## Verification
A timer that walks up to the compare word and stays there shows that the unit fires one event per equality and none while the value holds. A timer that jumps on and off the compare word shows that each new arrival starts a fresh event. Random mode values, spread over all sixteen codes, separate the four active actions from the disabled ones. Directed cycles place a clear beside a match, a zero-mode write beside a set-on-match, and a compare write beside an equal timer value, which tests each ordering rule. Toggling the ADC enable and the pin direction separates the gated outputs from the latch behind them.

// File: rtl/tcmp_pkg.sv
package tcmp_pkg;

    localparam int unsigned MODE_W = 4;

    typedef enum logic [MODE_W-1:0] {
        CM_OFF      = 4'b0000,
        CM_SET_HI   = 4'b1000,
        CM_DRV_LO   = 4'b1001,
        CM_SW_IRQ   = 4'b1010,
        CM_EVT_TRIG = 4'b1011
    } cmp_mode_e;

    // true when the raw mode code selects one of the four compare actions
    function automatic logic mode_active(input logic [MODE_W-1:0] m);
        return m[3:2] == 2'b10;
    endfunction

endpackage

// File: rtl/tcmp_match_det.sv
module tcmp_match_det #(
    parameter int unsigned CMP_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CMP_W-1:0] tmr_value,
    input  logic [CMP_W-1:0] cmp_word,
    input  logic             enable,
    output logic             hit
);
    typedef struct packed {
        logic eq_prev;
    } det_st_t;

    det_st_t st_d, st_q;
    logic    eq_now;

    always_comb begin
        eq_now        = (tmr_value == cmp_word);
        st_d          = st_q;
        st_d.eq_prev  = eq_now;
        // one event per arrival at the compare word
        hit           = eq_now && !st_q.eq_prev && enable;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/tcmp_action.sv
module tcmp_action
    import tcmp_pkg::*;
#(
    parameter bit HAS_ADC_LINK = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit,
    input  logic [MODE_W-1:0] mode,
    input  logic              force_low,
    input  logic              adc_enable,
    output logic              latch,
    output logic              trig,
    output logic              go
);
    typedef struct packed {
        logic latch;
        logic trig;
        logic go;
    } act_st_t;

    act_st_t st_d, st_q;
    logic    go_gate;

    generate
        if (HAS_ADC_LINK) begin : g_adc
            assign go_gate = adc_enable;
        end else begin : g_no_adc
            assign go_gate = 1'b0;
        end
    endgenerate

    always_comb begin
        st_d      = st_q;
        st_d.trig = 1'b0;
        st_d.go   = 1'b0;
        if (hit) begin
            unique case (mode)
                CM_SET_HI:   st_d.latch = 1'b1;
                CM_DRV_LO:   st_d.latch = 1'b0;
                CM_EVT_TRIG: begin
                    st_d.trig = 1'b1;
                    st_d.go   = go_gate;
                end
                default: ;
            endcase
        end
        // clearing the mode wins over a same-cycle match
        if (force_low) st_d.latch = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign latch = st_q.latch;
    assign trig  = st_q.trig;
    assign go    = st_q.go;
endmodule

// File: rtl/tcmp_flag.sv
module tcmp_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (clr) flag_d = 1'b0;
        if (set) flag_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag = flag_q;
endmodule

// File: rtl/tcmp_unit.sv
module tcmp_unit
    import tcmp_pkg::*;
#(
    parameter int unsigned CMP_W        = 16,
    parameter bit          HAS_ADC_LINK = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmp_we,
    input  logic [CMP_W-1:0] cmp_wdata,
    input  logic             mode_we,
    input  logic [3:0]       mode_wdata,
    input  logic [CMP_W-1:0] tmr_value,
    input  logic             adc_enable,
    input  logic             irq_clr,
    output logic             irq_flag,
    output logic             cmp_out,
    input  logic             pin_dir_out,
    output logic             pin_drive_en,
    output logic             pin_level,
    output logic             timer_clear,
    output logic             adc_go
);
    typedef struct packed {
        logic [CMP_W-1:0]  cmp;
        logic [MODE_W-1:0] mode;
    } cfg_st_t;

    cfg_st_t cfg_d, cfg_q;
    logic    hit, active, force_low, latch;

    always_comb begin
        cfg_d = cfg_q;
        if (cmp_we)  cfg_d.cmp  = cmp_wdata;
        if (mode_we) cfg_d.mode = mode_wdata;
        active    = mode_active(cfg_q.mode);
        force_low = mode_we && (mode_wdata == CM_OFF);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    tcmp_match_det #(.CMP_W(CMP_W)) det_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tmr_value (tmr_value),
        .cmp_word  (cfg_q.cmp),
        .enable    (active),
        .hit       (hit)
    );

    tcmp_action #(.HAS_ADC_LINK(HAS_ADC_LINK)) act_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit        (hit),
        .mode       (cfg_q.mode),
        .force_low  (force_low),
        .adc_enable (adc_enable),
        .latch      (latch),
        .trig       (timer_clear),
        .go         (adc_go)
    );

    tcmp_flag flag_i (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (hit),
        .clr   (irq_clr),
        .flag  (irq_flag)
    );

    always_comb begin
        cmp_out      = latch;
        pin_drive_en = pin_dir_out;
        pin_level    = pin_dir_out && latch;
    end
endmodule

// File: rtl/tcmp_unit_chk.sv
module tcmp_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       mode_we,
    input logic [3:0] mode_wdata,
    input logic       irq_clr,
    input logic       irq_flag,
    input logic       cmp_out,
    input logic       timer_clear,
    input logic       adc_go
);
    logic zero_wr;
    assign zero_wr = mode_we && (mode_wdata == 4'b0000);

    assert_flag_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_flag && !irq_clr |=> irq_flag);

    assert_flag_with_trig_R6: assert property (@(posedge clk) disable iff (!rst_n)
        timer_clear |-> irq_flag);

    assert_trig_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        timer_clear |=> !timer_clear);

    assert_trig_keeps_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        timer_clear && !$past(zero_wr) |-> $stable(cmp_out));

    assert_go_with_trig_R8: assert property (@(posedge clk) disable iff (!rst_n)
        adc_go |-> timer_clear);

    assert_zero_mode_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        zero_wr |=> !cmp_out);
endmodule

bind tcmp_unit tcmp_unit_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_we     (mode_we),
    .mode_wdata  (mode_wdata),
    .irq_clr     (irq_clr),
    .irq_flag    (irq_flag),
    .cmp_out     (cmp_out),
    .timer_clear (timer_clear),
    .adc_go      (adc_go)
);

// File: tb/tcmp_unit_tb_top.sv
module tcmp_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmp_we = 1'b0;
    logic [15:0] cmp_wdata = '0;
    logic        mode_we = 1'b0;
    logic [3:0]  mode_wdata = '0;
    logic [15:0] tmr_value = '0;
    logic        adc_enable = 1'b0;
    logic        irq_clr = 1'b0;
    logic        pin_dir_out = 1'b0;
    logic        irq_flag, cmp_out, pin_drive_en, pin_level, timer_clear, adc_go;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    tcmp_unit dut_i (
        .clk(clk), .rst_n(rst_n), .cmp_we(cmp_we), .cmp_wdata(cmp_wdata),
        .mode_we(mode_we), .mode_wdata(mode_wdata), .tmr_value(tmr_value),
        .adc_enable(adc_enable), .irq_clr(irq_clr), .irq_flag(irq_flag),
        .cmp_out(cmp_out), .pin_dir_out(pin_dir_out), .pin_drive_en(pin_drive_en),
        .pin_level(pin_level), .timer_clear(timer_clear), .adc_go(adc_go)
    );

    // expected state, derived from the requirements
    typedef struct packed {
        logic [15:0] cmp;
        logic [3:0]  mode;
        logic        eq_prev;
        logic        latch;
        logic        flag;
        logic        trig;
        logic        go;
    } mdl_t;

    mdl_t m;

    function automatic mdl_t mdl_next(input mdl_t s);
        mdl_t n = s;
        logic eq  = (tmr_value == s.cmp);
        logic act = (s.mode >= 4'd8) && (s.mode <= 4'd11);
        logic ev  = eq && !s.eq_prev && act;          // R2
        n.eq_prev = eq;
        n.trig = ev && (s.mode == 4'd11);              // R7
        n.go   = n.trig && adc_enable;                 // R8
        if (ev && s.mode == 4'd8) n.latch = 1'b1;      // R3
        if (ev && s.mode == 4'd9) n.latch = 1'b0;      // R4
        if (mode_we && mode_wdata == 4'd0) n.latch = 1'b0; // R9
        if (irq_clr) n.flag = 1'b0;
        if (ev) n.flag = 1'b1;                         // R6
        if (cmp_we) n.cmp = cmp_wdata;                 // R12
        if (mode_we) n.mode = mode_wdata;
        return n;
    endfunction

    task automatic check(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    // one clock: model steps with the applied inputs, outputs compared at negedge
    task automatic tick();
        mdl_t nx = mdl_next(m);
        @(posedge clk);
        m = nx;
        @(negedge clk);
        check("R3 latch", cmp_out, m.latch);
        check("R6 flag", irq_flag, m.flag);
        check("R7 trigger", timer_clear, m.trig);
        check("R8 adc go", adc_go, m.go);
        check("R10 drive enable", pin_drive_en, pin_dir_out);
        check("R10 pin level", pin_level, pin_dir_out && m.latch);
        cmp_we = 1'b0; mode_we = 1'b0; irq_clr = 1'b0;
    endtask

    task automatic wr_cmp(input logic [15:0] v);
        cmp_we = 1'b1; cmp_wdata = v; tick();
    endtask

    task automatic wr_mode(input logic [3:0] v);
        mode_we = 1'b1; mode_wdata = v; tick();
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
        end
    end

    initial begin
        m = '0;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 latch", cmp_out, 1'b0);
        check("R1 flag", irq_flag, 1'b0);
        check("R1 trigger", timer_clear, 1'b0);
        check("R1 adc go", adc_go, 1'b0);

        // R11: disabled mode with timer on the (zero) compare word
        tmr_value = 16'd5; tick();
        tmr_value = 16'd0; tick(); tick();
        check("R11 no flag", irq_flag, 1'b0);

        // R3 and R2: set high, held equality fires once
        pin_dir_out = 1'b1;
        wr_cmp(16'h0100);
        wr_mode(4'b1000);
        tmr_value = 16'h00FF; tick();
        tmr_value = 16'h0100; tick();
        check("R3 set high", cmp_out, 1'b1);
        check("R6 flag set", irq_flag, 1'b1);
        irq_clr = 1'b1; tick();
        check("R6 flag cleared", irq_flag, 1'b0);
        tick(); tick();
        check("R2 held equality no refire", irq_flag, 1'b0);

        // R9: zero write against a same-cycle set event
        tmr_value = 16'h0000; tick();
        tmr_value = 16'h0100; mode_we = 1'b1; mode_wdata = 4'b0000; tick();
        check("R9 zero write wins", cmp_out, 1'b0);
        check("R6 flag from event", irq_flag, 1'b1);

        // R4 drive low
        wr_mode(4'b1000); tmr_value = 16'h0001; tick();
        tmr_value = 16'h0100; tick();
        check("R3 high again", cmp_out, 1'b1);
        wr_mode(4'b1001); tmr_value = 16'h0002; tick();
        tmr_value = 16'h0100; tick();
        check("R4 drive low", cmp_out, 1'b0);

        // R5: software interrupt mode leaves latch, set wins over clear
        wr_mode(4'b1000); tmr_value = 16'h0003; tick();
        tmr_value = 16'h0100; tick();
        wr_mode(4'b1010); tmr_value = 16'h0004; tick();
        irq_clr = 1'b1; tick();
        tmr_value = 16'h0100; irq_clr = 1'b1; tick();
        check("R5 latch kept", cmp_out, 1'b1);
        check("R6 set beats clear", irq_flag, 1'b1);

        // R7 and R8 trigger with and without ADC enable
        wr_mode(4'b1011); tmr_value = 16'h0005; adc_enable = 1'b1; tick();
        tmr_value = 16'h0100; tick();
        check("R7 trigger pulse", timer_clear, 1'b1);
        check("R8 go pulse", adc_go, 1'b1);
        tmr_value = 16'h0000; tick();
        check("R7 single pulse", timer_clear, 1'b0);
        adc_enable = 1'b0; tmr_value = 16'h0100; tick();
        check("R8 go blocked", adc_go, 1'b0);
        check("R7 trigger again", timer_clear, 1'b1);

        // R12: compare write with timer already at the new value
        tmr_value = 16'h0200; cmp_we = 1'b1; cmp_wdata = 16'h0200; irq_clr = 1'b1; tick();
        check("R12 no match during write", timer_clear, 1'b0);
        tmr_value = 16'h0201; tick();
        tmr_value = 16'h0200; tick();
        check("R12 new word matches", timer_clear, 1'b1);

        // R10 pin gating
        pin_dir_out = 1'b0; tick();
        check("R10 pin low when input", pin_level, 1'b0);
        pin_dir_out = 1'b1;

        // random mix
        for (int i = 0; i < 4000; i++) begin
            int r = $urandom_range(0, 99);
            if (r < 4) begin
                mode_we = 1'b1;
                mode_wdata = ($urandom_range(0, 3) == 0) ? 4'($urandom_range(0, 15))
                                                         : 4'(8 + $urandom_range(0, 3));
            end
            if (r >= 4 && r < 7) begin
                cmp_we = 1'b1; cmp_wdata = 16'($urandom_range(0, 7));
            end
            irq_clr     = ($urandom_range(0, 9) == 0);
            adc_enable  = $urandom_range(0, 1) == 1;
            pin_dir_out = ($urandom_range(0, 7) != 0);
            tmr_value   = 16'($urandom_range(0, 7));
            tick();
        end

        done = 1'b1;
        summary();
    end
endmodule